// File: doc/BRIEF.md
# Scatter List Descriptor Table Generator

This block turns a list of memory segments, each given as a start address and a byte length, into a table of transfer descriptors in memory. A downstream transfer engine later walks that table. The block splits every segment so that no descriptor spans a 64 KiB address boundary. Each descriptor is written as four 32-bit words through a single word-write port, one word per cycle, starting at a table base address.

When the list ends, the block writes the final length word a second time with the end-of-list flag set. It then reports the number of descriptors it built. An empty list, or a list that needs more descriptors than the table holds, does not produce a usable table. In that case the block reports a failure with a count of zero.

Segments arrive on a valid/ready stream, and a last flag marks the final segment of a list. The table base is sampled when the first non-empty segment of a list is accepted. The base must be 16-byte aligned.

Top module: `dtab_builder`

## Requirements
- R1: The length of each descriptor is the smaller of two values: the bytes left in the segment, and 0x10000 minus the low 16 bits of the current address. A descriptor therefore never crosses a 64 KiB boundary, and its length can be as large as 0x10000.
- R2: After each descriptor, the current address rises by the descriptor length and the bytes left fall by the same amount. Descriptors are produced in list order until the segment is used up. Descriptor k (counting from 0) occupies bytes base+16k to base+16k+15.
- R3: A descriptor is written as four words in ascending address order: offset 0 holds zero; offset 4 holds the byte-swapped 32-bit address (byte 0 exchanged with byte 3, byte 1 with byte 2); offset 8 holds zero; offset 12 holds the byte-swapped length word. In the length word before swapping, bits 16:0 carry the length and bit 31 is the end-of-list flag.
- R4: After the final descriptor of a successful list, the block rewrites that descriptor's length word at the same address with bit 31 set. This is one extra write, and it comes before the completion pulse.
- R5: A successful list ends with a completion pulse one cycle long. During that cycle the fail output is low and the count output equals the number of descriptors written, which is between 1 and the capacity.
- R6: The capacity is MAX_DESC descriptors. If a descriptor beyond the capacity is needed, the block writes nothing further and skips the end-of-list rewrite. It accepts and discards the rest of the list up to the segment marked last, then gives a completion pulse with fail high and count zero.
- R7: If the first segment of a list has length zero, the result is a completion pulse with fail high and count zero, and no memory writes. This includes a one-segment list with length zero.
- R8: A zero-length segment after at least one descriptor ends the list early. The descriptors already written are kept and the last one receives the end-of-list flag. Later segments of the list are accepted but produce no writes.
- R9: Segment ready is low during every memory write, so it stays low while a segment is being split. Ready is high whenever the block is waiting for a segment or discarding segments.
- R10: After reset, ready is high, and write enable, done and fail are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segValid | input | 1 | Segment offered |
| segReady | output | 1 | Block can take a segment |
| segAddr | input | ADDR_W | Segment start byte address |
| segLen | input | LEN_W | Segment length in bytes |
| segLast | input | 1 | Segment is the last of the list |
| tableBase | input | ADDR_W | Byte address of descriptor table |
| wrEn | output | 1 | Table word write strobe |
| wrAddr | output | ADDR_W | Byte address of the table word |
| wrData | output | 32 | Table word value |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Qualifies done: list rejected |
| descCount | output | CNT_W | Descriptors built, valid with done |

## Verification
Two functions can land on the same descriptor: the capacity check and the end-of-list rewrite. The bench sends one segment that needs exactly MAX_DESC descriptors, so the last descriptor fills the final table slot and must still get its end-of-list rewrite and a successful count. It then sends a segment that needs one more descriptor, which must abort with a failure and no rewrite. A scoreboard compares every table write and every completion result against a model computed from the requirements.

// File: rtl/dtab_pkg.sv
package dtab_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EMIT,
    ST_DRAIN,
    ST_EOL,
    ST_DONE
  } dtabState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadSeg;
    logic       advance;
    logic       clrCount;
    logic       wrEn;
    logic       selEol;
    logic [1:0] wordSel;
  } dtabStrb_t;

  function automatic logic [31:0] swapBytes(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/dtab_datapath.sv
module dtab_datapath
  import dtab_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 32,
  parameter int MAX_DESC = 64,
  parameter int CNT_W    = $clog2(MAX_DESC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dtabStrb_t         strb,
  input  logic [ADDR_W-1:0] segAddr,
  input  logic [LEN_W-1:0]  segLen,
  input  logic [ADDR_W-1:0] tableBase,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic [CNT_W-1:0]  count,
  output logic              chunkIsLast,
  output logic              tableFull,
  output logic              listEmpty,
  output logic              segLenZero
);

  localparam int CHUNK_W = 17;
  localparam logic [CHUNK_W-1:0] WINDOW = CHUNK_W'(17'h10000);
  localparam logic [31:0] EOL_BIT = 32'h8000_0000;

  logic [ADDR_W-1:0]  curAddr;
  logic [LEN_W-1:0]   remLen;
  logic [ADDR_W-1:0]  baseQ;
  logic [ADDR_W-1:0]  savedLenAddr;
  logic [CHUNK_W-1:0] savedLen;
  logic [CHUNK_W-1:0] room;
  logic [CHUNK_W-1:0] chunk;
  logic [ADDR_W-1:0]  descAddr;
  logic [31:0]        addrWord;
  logic [31:0]        lenWord;

  // bytes left before the next 64 KiB boundary
  assign room  = WINDOW - {1'b0, curAddr[15:0]};
  assign chunk = (remLen < LEN_W'(room)) ? remLen[CHUNK_W-1:0] : room;

  assign chunkIsLast = (remLen == LEN_W'(chunk));
  assign tableFull   = (count == CNT_W'(MAX_DESC));
  assign listEmpty   = (count == '0);
  assign segLenZero  = (segLen == '0);

  assign descAddr = baseQ + (ADDR_W'(count) << 4);
  assign addrWord = 32'(curAddr);
  assign lenWord  = 32'(chunk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr      <= '0;
      remLen       <= '0;
      baseQ        <= '0;
      savedLenAddr <= '0;
      savedLen     <= '0;
      count        <= '0;
    end else begin
      if (strb.loadSeg) begin
        curAddr <= segAddr;
        remLen  <= segLen;
        if (count == '0) baseQ <= tableBase;
      end
      if (strb.advance) begin
        curAddr      <= curAddr + ADDR_W'(chunk);
        remLen       <= remLen - LEN_W'(chunk);
        count        <= count + 1'b1;
        savedLenAddr <= descAddr + ADDR_W'(12);
        savedLen     <= chunk;
      end
      if (strb.clrCount) count <= '0;
    end
  end

  always_comb begin
    if (strb.selEol) begin
      wrAddr = savedLenAddr;
      wrData = swapBytes(32'(savedLen) | EOL_BIT);
    end else begin
      wrAddr = descAddr + ADDR_W'({strb.wordSel, 2'b00});
      case (strb.wordSel)
        2'd1:    wrData = swapBytes(addrWord);
        2'd3:    wrData = swapBytes(lenWord);
        default: wrData = '0;
      endcase
    end
  end

endmodule

// File: rtl/dtab_ctrl.sv
module dtab_ctrl
  import dtab_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      segValid,
  input  logic      segLast,
  input  logic      segLenZero,
  input  logic      chunkIsLast,
  input  logic      tableFull,
  input  logic      listEmpty,
  output logic      segReady,
  output dtabStrb_t strb,
  output logic      done,
  output logic      fail
);

  dtabState_t state, stateN;
  logic [1:0] phase, phaseN;
  logic       lastQ, lastN;
  logic       failQ, failN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
      lastQ <= 1'b0;
      failQ <= 1'b0;
    end else begin
      state <= stateN;
      phase <= phaseN;
      lastQ <= lastN;
      failQ <= failN;
    end
  end

  always_comb begin
    stateN   = state;
    phaseN   = phase;
    lastN    = lastQ;
    failN    = failQ;
    strb     = '0;
    segReady = 1'b0;
    done     = 1'b0;
    fail     = 1'b0;
    case (state)
      ST_IDLE: begin
        segReady = 1'b1;
        if (segValid) begin
          if (segLenZero) begin
            if (!segLast) begin
              stateN = ST_DRAIN;
            end else if (listEmpty) begin
              failN  = 1'b1;
              stateN = ST_DONE;
            end else begin
              stateN = ST_EOL;
            end
          end else begin
            strb.loadSeg = 1'b1;
            lastN        = segLast;
            phaseN       = '0;
            stateN       = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        if (phase == 2'd0 && tableFull) begin
          failN  = 1'b1;
          stateN = lastQ ? ST_DONE : ST_DRAIN;
        end else begin
          strb.wrEn    = 1'b1;
          strb.wordSel = phase;
          phaseN       = phase + 1'b1;
          if (phase == 2'd3) begin
            strb.advance = 1'b1;
            if (chunkIsLast) stateN = lastQ ? ST_EOL : ST_IDLE;
          end
        end
      end
      ST_DRAIN: begin
        segReady = 1'b1;
        if (segValid && segLast) begin
          if (failQ || listEmpty) begin
            failN  = 1'b1;
            stateN = ST_DONE;
          end else begin
            stateN = ST_EOL;
          end
        end
      end
      ST_EOL: begin
        strb.wrEn   = 1'b1;
        strb.selEol = 1'b1;
        stateN      = ST_DONE;
      end
      ST_DONE: begin
        done          = 1'b1;
        fail          = failQ;
        strb.clrCount = 1'b1;
        failN         = 1'b0;
        stateN        = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dtab_builder.sv
module dtab_builder
  import dtab_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 32,
  parameter int MAX_DESC = 64,
  parameter int CNT_W    = $clog2(MAX_DESC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              segValid,
  output logic              segReady,
  input  logic [ADDR_W-1:0] segAddr,
  input  logic [LEN_W-1:0]  segLen,
  input  logic              segLast,
  input  logic [ADDR_W-1:0] tableBase,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  descCount
);

  dtabStrb_t        strb;
  logic [CNT_W-1:0] count;
  logic             chunkIsLast;
  logic             tableFull;
  logic             listEmpty;
  logic             segLenZero;

  dtab_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .segValid   (segValid),
    .segLast    (segLast),
    .segLenZero (segLenZero),
    .chunkIsLast(chunkIsLast),
    .tableFull  (tableFull),
    .listEmpty  (listEmpty),
    .segReady   (segReady),
    .strb       (strb),
    .done       (done),
    .fail       (fail)
  );

  dtab_datapath #(
    .ADDR_W  (ADDR_W),
    .LEN_W   (LEN_W),
    .MAX_DESC(MAX_DESC),
    .CNT_W   (CNT_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .segAddr    (segAddr),
    .segLen     (segLen),
    .tableBase  (tableBase),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .count      (count),
    .chunkIsLast(chunkIsLast),
    .tableFull  (tableFull),
    .listEmpty  (listEmpty),
    .segLenZero (segLenZero)
  );

  assign wrEn      = strb.wrEn;
  assign descCount = (done && !fail) ? count : '0;

endmodule

// File: rtl/dtab_checker.sv
module dtab_checker #(
  parameter int MAX_DESC = 64,
  parameter int CNT_W    = $clog2(MAX_DESC + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             segReady,
  input logic             wrEn,
  input logic             done,
  input logic             fail,
  input logic [CNT_W-1:0] descCount
);

  AST_NO_READY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !segReady); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5

  AST_GOOD_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fail) |-> (descCount != '0 && descCount <= CNT_W'(MAX_DESC))); // R5

  AST_FAIL_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (done && fail) |-> descCount == '0); // R6

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> done); // R7

  AST_NO_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrEn); // R4

endmodule

bind dtab_builder dtab_checker #(
  .MAX_DESC(MAX_DESC),
  .CNT_W   (CNT_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .segReady (segReady),
  .wrEn     (wrEn),
  .done     (done),
  .fail     (fail),
  .descCount(descCount)
);

// File: tb/dtab_builder_test.sv
module dtab_builder_test;

  localparam int MAXD  = 64;
  localparam int CNT_W = $clog2(MAXD + 1);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segValid = 1'b0;
  logic        segReady;
  logic [31:0] segAddr = '0;
  logic [31:0] segLen = '0;
  logic        segLast = 1'b0;
  logic [31:0] tableBase = '0;
  logic        wrEn;
  logic [31:0] wrAddr;
  logic [31:0] wrData;
  logic        done;
  logic        fail;
  logic [CNT_W-1:0] descCount;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [63:0] expWr[$];
  string       expWrTag[$];
  logic [31:0] expRes[$];
  string       expResTag[$];

  logic [31:0] listA[8];
  logic [31:0] listL[8];

  always #2.5 clk = ~clk;

  dtab_builder #(.MAX_DESC(MAXD)) uut (
    .clk(clk), .rstN(rstN), .segValid(segValid), .segReady(segReady),
    .segAddr(segAddr), .segLen(segLen), .segLast(segLast),
    .tableBase(tableBase), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .done(done), .fail(fail), .descCount(descCount)
  );

  function automatic logic [31:0] bsw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops and compares at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      if (wrEn) begin
        check(!segReady, "R9 ready during write", {63'b0, segReady}, 64'd0);
        if (expWr.size() == 0)
          check(1'b0, "R2 unexpected write", {wrAddr, wrData}, 64'd0);
        else
          check({wrAddr, wrData} == expWr[0], expWrTag[0], {wrAddr, wrData}, expWr[0]);
        if (expWr.size() != 0) begin
          void'(expWr.pop_front());
          void'(expWrTag.pop_front());
        end
      end
      if (done) begin
        if (expRes.size() == 0)
          check(1'b0, "R5 unexpected done", {31'b0, fail, 32'(descCount)}, 64'd0);
        else
          check({fail, 31'(descCount)} == expRes[0], expResTag[0],
                {32'b0, fail, 31'(descCount)}, {32'b0, expRes[0]});
        if (expRes.size() != 0) begin
          void'(expRes.pop_front());
          void'(expResTag.pop_front());
        end
      end
    end
  end

  // driver: build expected items from the requirements, then send segments
  task automatic runList(input int n, input logic [31:0] base, input string tag);
    int cnt = 0;
    bit stop = 1'b0;
    bit abort = 1'b0;
    logic [31:0] lastLen = '0;
    logic [31:0] lastAddr = '0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] a = listA[i];
      logic [31:0] rem = listL[i];
      if (!stop) begin
        if (rem == 0) stop = 1'b1;
        while (!stop && rem != 0) begin
          logic [31:0] room = 32'h10000 - (a & 32'hFFFF);
          logic [31:0] c = (rem < room) ? rem : room;
          logic [31:0] d = base + 32'(cnt) * 16;
          if (cnt == MAXD) begin
            abort = 1'b1;
            stop = 1'b1;
          end else begin
            expWr.push_back({d, 32'h0});        expWrTag.push_back({tag, " word0"});
            expWr.push_back({d + 4, bsw(a)});   expWrTag.push_back({tag, " addr word"});
            expWr.push_back({d + 8, 32'h0});    expWrTag.push_back({tag, " word2"});
            expWr.push_back({d + 12, bsw(c)});  expWrTag.push_back({tag, " len word"});
            lastLen = c;
            lastAddr = d + 12;
            a = a + c;
            rem = rem - c;
            cnt++;
          end
        end
      end
    end
    if (abort || cnt == 0) begin
      expRes.push_back(32'h8000_0000);
      expResTag.push_back({tag, " fail result"});
    end else begin
      expWr.push_back({lastAddr, bsw(lastLen | 32'h8000_0000)});
      expWrTag.push_back({tag, " R4 eol rewrite"});
      expRes.push_back(32'(cnt));
      expResTag.push_back({tag, " R5 count"});
    end
    tableBase = base;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      segValid = 1'b1;
      segAddr = listA[i];
      segLen = listL[i];
      segLast = (i == n - 1);
      while (!segReady) @(negedge clk);
      @(negedge clk);
      segValid = 1'b0;
      segLast = 1'b0;
    end
    while (expRes.size() != 0) @(negedge clk);
    check(expWr.size() == 0, {tag, " leftover writes"}, 64'(expWr.size()), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(segReady && !wrEn && !done && !fail, "R10 reset outputs",
          {60'b0, segReady, wrEn, done, fail}, 64'h8);

    // R3 single segment, no boundary crossing
    listA[0] = 32'h1000_0100; listL[0] = 32'h200;
    runList(1, 32'h4000_0000, "R3");

    // R1 boundary crossing splits into 0x100 and 0x200
    listA[0] = 32'h0001_FF00; listL[0] = 32'h300;
    runList(1, 32'h4000_1000, "R1");

    // R1 aligned full windows: length 0x10000 each
    listA[0] = 32'h0002_0000; listL[0] = 32'h2_0000;
    runList(1, 32'h4000_2000, "R1 full");

    // R2 multi-segment list
    listA[0] = 32'h0000_FFF0; listL[0] = 32'h20;
    listA[1] = 32'h0050_0000; listL[1] = 32'h1234;
    listA[2] = 32'h7FFF_8000; listL[2] = 32'h1_0000;
    runList(3, 32'h4000_3000, "R2");

    // R7 empty list
    listA[0] = 32'h0000_1000; listL[0] = 32'h0;
    runList(1, 32'h4000_4000, "R7");

    // R7 zero first segment followed by others
    listA[0] = 32'h0000_1000; listL[0] = 32'h0;
    listA[1] = 32'h0000_2000; listL[1] = 32'h40;
    runList(2, 32'h4000_4000, "R7 drain");

    // R8 zero mid list
    listA[0] = 32'h0003_0000; listL[0] = 32'h80;
    listA[1] = 32'h0004_0000; listL[1] = 32'h0;
    listA[2] = 32'h0005_0000; listL[2] = 32'h100;
    runList(3, 32'h4000_5000, "R8");

    // R6 exactly at capacity succeeds
    listA[0] = 32'h0100_0000; listL[0] = 32'(MAXD) * 32'h1_0000;
    runList(1, 32'h4001_0000, "R6 at capacity");

    // R6 one beyond capacity fails, later segment discarded
    listA[0] = 32'h0100_0000; listL[0] = 32'(MAXD + 1) * 32'h1_0000;
    listA[1] = 32'h0200_0000; listL[1] = 32'h100;
    runList(2, 32'h4002_0000, "R6 overflow");

    // R6 overflow on a last segment
    listA[0] = 32'h0100_8000; listL[0] = 32'(MAXD) * 32'h1_0000;
    runList(1, 32'h4003_0000, "R6 overflow last");

    // back to normal after failures
    listA[0] = 32'h00AB_CDEF; listL[0] = 32'h11;
    runList(1, 32'h4004_0000, "R3 after fail");

    repeat (4) @(negedge clk);
    check(!done && !wrEn && segReady, "R9 idle ready",
          {61'b0, done, wrEn, segReady}, 64'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule